// File: doc/BRIEF.md
# Energy-Paced Scan Clock Generator

This block drives the test clock for power-limited scan testing. Each test cycle has its own length. Before a run, a small table is loaded with one pre-computed energy figure per test cycle. During the run, each cycle lasts as long as its energy divided by the power budget, counted in whole reference ticks. A cycle is never shorter than the critical-path floor for its kind, and the floor for shift cycles is set apart from the floor for capture cycles. Cycles with little energy therefore run fast and cycles with much energy run slow. The whole test then takes about the total energy divided by the budget, not the cycle count times the worst cycle.

A fixed-rate mode is kept for comparison. It first scans the table for its largest entry, then runs every cycle at the period that entry needs. For each cycle the block also drives a scan-enable tag (shift or capture) and counts the reference ticks the run takes. It raises done when the run is over.

Top module: `scan_pace_clkgen`

## Requirements
- R1: After reset, tck_o, se_o, busy_o and done_o are 0 and elapsed_o is 0. While busy_o is 0, tck_o and se_o stay 0.
- R2: In variable mode, the period of cycle k in reference ticks is max(ceil(E[k]/P), F, 2). E[k] is table entry k and P is pmax_i, where a pmax_i of 0 counts as 1. F is dly_cap_i for a capture cycle and dly_shift_i for a shift cycle.
- R3: Each period begins with tck_o high for floor(period/2) ticks. tck_o is then low for the remaining ticks of the period.
- R4: A run has exactly (N_COMB+2)*N_SFF + N_COMB + 4 pulses, and table entry k belongs to pulse k. The run opens with N_SFF+2 shift cycles. Then, for each of the N_COMB vectors, there are N_SFF shift cycles followed by one capture cycle. The run closes with N_SFF+2 shift cycles. se_o is 1 during a shift pulse and 0 during a capture pulse, and it holds steady while tck_o is high.
- R5: In fixed mode (sync_mode_i = 1 when the run starts), every period equals max(ceil(Emax/P), max(dly_shift_i, dly_cap_i), 2). Emax is the largest of the table entries in use.
- R6: When done_o rises, elapsed_o equals the sum of all the periods. It then holds until the next start. If every E[k] is a multiple of P and no floor applies, elapsed_o equals (sum of E[k])/P.
- R7: done_o rises exactly sum-of-periods ticks after the first rising edge of tck_o, on the same edge where busy_o falls. done_o and busy_o are never high together.
- R8: Table writes made while busy_o is 1 are dropped. A later run still uses the entries held before those writes.
- R9: start_i is ignored while busy_o is 1. A start received while idle sets busy_o on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; one edge is one tick |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (sampled while idle) |
| sync_mode_i | input | 1 | 1 selects fixed worst-case period, sampled at start |
| pmax_i | input | P_W | Power budget divisor (0 treated as 1) |
| dly_shift_i | input | D_W | Minimum period for shift cycles, ticks |
| dly_cap_i | input | D_W | Minimum period for capture cycles, ticks |
| tbl_we_i | input | 1 | Energy table write enable (idle only) |
| tbl_addr_i | input | AW | Energy table write address |
| tbl_data_i | input | E_W | Energy value to write |
| tck_o | output | 1 | Paced test clock |
| se_o | output | 1 | Scan enable tag for the current pulse |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, result valid |
| elapsed_o | output | ET_W | Reference ticks taken by the last run |

## Verification
The bench builds the block with N_SFF = 3 and N_COMB = 2. That gives an 18-cycle run with capture pulses at positions 8 and 12, short enough to measure the high and low length of every pulse in every run. Energy patterns, budgets and floors are chosen to reach each limit that can set a period: the energy quotient with and without a remainder, the shift floor, the capture floor, the two-tick minimum and a zero budget. Fixed mode and the exact Etotal/P case are also covered. Writes and a start are injected in the middle of a run, and the table is checked afterwards through a second run.

// File: rtl/scan_pace_pkg.sv
package scan_pace_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEAK,
    ST_RUN,
    ST_FIN
  } pace_st_e;
endpackage

// File: rtl/energy_tbl.sv
module energy_tbl #(
  parameter int E_W   = 12,
  parameter int DEPTH = 18,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [E_W-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [E_W-1:0] rdata_o
);
  localparam logic [AW:0] LIM = (AW+1)'(DEPTH);

  logic [E_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && ({1'b0, waddr_i} < LIM)) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = ({1'b0, raddr_i} < LIM) ? mem[raddr_i] : '0;
endmodule

// File: rtl/cycle_tag.sv
module cycle_tag #(
  parameter int N_SFF  = 3,
  parameter int N_COMB = 2,
  parameter int AW     = 5
) (
  input  logic [AW-1:0] idx_i,
  output logic          cap_o
);
  localparam int unsigned PRE      = N_SFF + 2;
  localparam int unsigned SEG      = N_SFF + 1;
  localparam int unsigned LOAD_END = PRE + N_COMB * SEG;

  logic [31:0] k;
  assign k = 32'(idx_i);
  // capture closes each load segment
  assign cap_o = (k >= PRE) && (k < LOAD_END) && (((k - PRE) % SEG) == SEG - 1);
endmodule

// File: rtl/period_calc.sv
module period_calc #(
  parameter int E_W = 12,
  parameter int P_W = 8,
  parameter int D_W = 8
) (
  input  logic [E_W-1:0] energy_i,
  input  logic [P_W-1:0] pmax_i,
  input  logic [D_W-1:0] floor_i,
  output logic [E_W:0]   per_o
);
  localparam int PW = E_W + 1;

  logic [P_W-1:0] pm;
  logic [PW-1:0]  num;
  logic [PW-1:0]  quo;

  always_comb begin
    pm  = (pmax_i == '0) ? P_W'(1) : pmax_i;
    num = {1'b0, energy_i} + PW'(pm) - PW'(1);
    quo = num / PW'(pm);
    per_o = quo;
    if (per_o < PW'(floor_i)) per_o = PW'(floor_i);
    if (per_o < PW'(2))       per_o = PW'(2);
  end
endmodule

// File: rtl/scan_pace_clkgen.sv
module scan_pace_clkgen
  import scan_pace_pkg::*;
#(
  parameter int N_SFF  = 3,
  parameter int N_COMB = 2,
  parameter int E_W    = 12,
  parameter int P_W    = 8,
  parameter int D_W    = 8,
  parameter int ET_W   = 24,
  localparam int N_CYC = (N_COMB + 2) * N_SFF + N_COMB + 4,
  localparam int AW    = $clog2(N_CYC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            sync_mode_i,
  input  logic [P_W-1:0]  pmax_i,
  input  logic [D_W-1:0]  dly_shift_i,
  input  logic [D_W-1:0]  dly_cap_i,
  input  logic            tbl_we_i,
  input  logic [AW-1:0]   tbl_addr_i,
  input  logic [E_W-1:0]  tbl_data_i,
  output logic            tck_o,
  output logic            se_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [ET_W-1:0] elapsed_o
);
  localparam int PW = E_W + 1;
  localparam logic [AW-1:0] LAST = AW'(N_CYC - 1);

  pace_st_e       st_q;
  logic [AW-1:0]  idx_q;
  logic [PW-1:0]  tick_q;
  logic [E_W-1:0] emax_q;
  logic           mode_q;
  logic           tck_q, se_q, done_q;
  logic [ET_W-1:0] elapsed_q;

  logic [E_W-1:0] rdata;
  logic           cap;
  logic [E_W-1:0] en_sel;
  logic [D_W-1:0] flr_sel;
  logic [PW-1:0]  per;

  energy_tbl #(.E_W(E_W), .DEPTH(N_CYC), .AW(AW)) u_tbl (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i && (st_q == ST_IDLE)),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (idx_q),
    .rdata_o (rdata)
  );

  cycle_tag #(.N_SFF(N_SFF), .N_COMB(N_COMB), .AW(AW)) u_tag (
    .idx_i (idx_q),
    .cap_o (cap)
  );

  always_comb begin
    if (mode_q) begin
      en_sel  = emax_q;
      flr_sel = (dly_shift_i > dly_cap_i) ? dly_shift_i : dly_cap_i;
    end else begin
      en_sel  = rdata;
      flr_sel = cap ? dly_cap_i : dly_shift_i;
    end
  end

  period_calc #(.E_W(E_W), .P_W(P_W), .D_W(D_W)) u_per (
    .energy_i (en_sel),
    .pmax_i   (pmax_i),
    .floor_i  (flr_sel),
    .per_o    (per)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      tick_q    <= '0;
      emax_q    <= '0;
      mode_q    <= 1'b0;
      tck_q     <= 1'b0;
      se_q      <= 1'b0;
      done_q    <= 1'b0;
      elapsed_q <= '0;
    end else begin
      tck_q <= (st_q == ST_RUN) && (tick_q < (per >> 1));
      se_q  <= (st_q == ST_RUN) && !cap;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            done_q    <= 1'b0;
            elapsed_q <= '0;
            idx_q     <= '0;
            tick_q    <= '0;
            emax_q    <= '0;
            mode_q    <= sync_mode_i;
            st_q      <= sync_mode_i ? ST_PEAK : ST_RUN;
          end
        end
        ST_PEAK: begin
          if (rdata > emax_q) emax_q <= rdata;
          if (idx_q == LAST) begin
            idx_q <= '0;
            st_q  <= ST_RUN;
          end else begin
            idx_q <= idx_q + AW'(1);
          end
        end
        ST_RUN: begin
          elapsed_q <= elapsed_q + ET_W'(1);
          if (tick_q == per - PW'(1)) begin
            tick_q <= '0;
            if (idx_q == LAST) st_q <= ST_FIN;
            else               idx_q <= idx_q + AW'(1);
          end else begin
            tick_q <= tick_q + PW'(1);
          end
        end
        ST_FIN: begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tck_o     = tck_q;
  assign se_o      = se_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign elapsed_o = elapsed_q;
endmodule

// File: rtl/scan_pace_chk.sv
module scan_pace_chk #(
  parameter int ET_W = 24
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            tck_o,
  input logic            se_o,
  input logic            busy_o,
  input logic            done_o,
  input logic [ET_W-1:0] elapsed_o
);
  p_done_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tck_o && !se_o));

  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(elapsed_o)));

  p_count_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (elapsed_o >= $past(elapsed_o)));

  p_tag_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o && $past(tck_o)) |-> $stable(se_o));

  p_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind scan_pace_clkgen scan_pace_chk #(.ET_W(ET_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .tck_o     (tck_o),
  .se_o      (se_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .elapsed_o (elapsed_o)
);

// File: tb/scan_pace_clkgen_test.sv
module scan_pace_clkgen_test;
  localparam int N_SFF  = 3;
  localparam int N_COMB = 2;
  localparam int E_W    = 12;
  localparam int P_W    = 8;
  localparam int D_W    = 8;
  localparam int ET_W   = 24;
  localparam int N_CYC  = (N_COMB + 2) * N_SFF + N_COMB + 4;
  localparam int AW     = $clog2(N_CYC);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, sync_mode_i = 1'b0;
  logic [P_W-1:0] pmax_i = '0;
  logic [D_W-1:0] dly_shift_i = '0, dly_cap_i = '0;
  logic tbl_we_i = 1'b0;
  logic [AW-1:0] tbl_addr_i = '0;
  logic [E_W-1:0] tbl_data_i = '0;
  logic tck_o, se_o, busy_o, done_o;
  logic [ET_W-1:0] elapsed_o;

  int nchk = 0, errs = 0;
  int ev [N_CYC];
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  scan_pace_clkgen #(.N_SFF(N_SFF), .N_COMB(N_COMB), .E_W(E_W), .P_W(P_W),
                     .D_W(D_W), .ET_W(ET_W)) uut (.*);

  task automatic chk(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_cap(int k);
    int pre = N_SFF + 2;
    int seg = N_SFF + 1;
    return (k >= pre) && (k < pre + N_COMB * seg) && (((k - pre) % seg) == seg - 1);
  endfunction

  function automatic int cdiv(int e, int p);
    int pp = (p == 0) ? 1 : p;
    return (e + pp - 1) / pp;
  endfunction

  function automatic int exp_per(int k, bit sync);
    int q, f, em;
    if (sync) begin
      em = 0;
      for (int j = 0; j < N_CYC; j++) if (ev[j] > em) em = ev[j];
      q = cdiv(em, int'(pmax_i));
      f = (dly_shift_i > dly_cap_i) ? int'(dly_shift_i) : int'(dly_cap_i);
    end else begin
      q = cdiv(ev[k], int'(pmax_i));
      f = exp_cap(k) ? int'(dly_cap_i) : int'(dly_shift_i);
    end
    if (q < f) q = f;
    if (q < 2) q = 2;
    return q;
  endfunction

  task automatic load_tbl();
    for (int k = 0; k < N_CYC; k++) begin
      @(negedge clk_i);
      tbl_we_i = 1'b1; tbl_addr_i = AW'(k); tbl_data_i = E_W'(ev[k]);
    end
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  // runs one test and checks every pulse; returns the measured total
  task automatic run_test(bit sync, bit inject, output int total);
    int wait_t, pulses, hi, lo, expp, sum;
    bit seen;
    total = 0; sum = 0; pulses = 0;
    @(negedge clk_i);
    sync_mode_i = sync; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R9 busy after start", busy_o, 1);
    if (inject) begin
      fork
        begin
          repeat (20) @(negedge clk_i);
          start_i = 1'b1; tbl_we_i = 1'b1; tbl_addr_i = '0; tbl_data_i = E_W'(4000);
          @(negedge clk_i);
          start_i = 1'b0; tbl_we_i = 1'b0;
        end
      join_none
    end
    wait_t = 0;
    while (!tck_o && wait_t < 200) begin @(negedge clk_i); wait_t++; end
    for (int c = 0; c < N_CYC; c++) begin
      if (done_o || !tck_o) break;
      pulses++;
      expp = exp_per(c, sync);
      sum += expp;
      chk(se_o === !exp_cap(c), "R4 scan tag", se_o, !exp_cap(c));
      hi = 0; lo = 0; seen = 0;
      while (tck_o && hi < 5000) begin @(negedge clk_i); hi++; end
      while (!tck_o && !done_o && lo < 5000) begin @(negedge clk_i); lo++; end
      chk(hi + lo == expp, sync ? "R5 fixed period" : "R2 period", hi + lo, expp);
      chk(hi == expp / 2, "R3 high phase", hi, expp / 2);
      total += hi + lo;
    end
    chk(pulses == N_CYC, "R4 pulse count", pulses, N_CYC);
    chk(done_o === 1'b1 && busy_o === 1'b0, "R7 done with busy low", {done_o, busy_o}, 2);
    chk(total == sum, "R7 done timing", total, sum);
    chk(int'(elapsed_o) == sum, "R6 elapsed total", elapsed_o, sum);
    repeat (3) @(negedge clk_i);
    chk(int'(elapsed_o) == sum && done_o, "R6 elapsed held", elapsed_o, sum);
  endtask

  initial begin
    int tot, etot;
    repeat (3) @(negedge clk_i);
    chk(tck_o === 1'b0 && se_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
        "R1 reset outputs", {tck_o, se_o, busy_o, done_o}, 0);
    chk(elapsed_o === '0, "R1 reset elapsed", elapsed_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(busy_o === 1'b0 && tck_o === 1'b0, "R1 idle after reset", busy_o, 0);

    // R2 mixed energies, floors active on some cycles
    for (int k = 0; k < N_CYC; k++) ev[k] = (k * 37 + 13) % 200;
    load_tbl();
    pmax_i = 8'd10; dly_shift_i = 8'd3; dly_cap_i = 8'd9;
    run_test(0, 0, tot);

    // R2 two-tick minimum and ceiling
    for (int k = 0; k < N_CYC; k++) ev[k] = (k * 29) % 121;
    load_tbl();
    pmax_i = 8'd50; dly_shift_i = 8'd0; dly_cap_i = 8'd0;
    run_test(0, 0, tot);

    // R2 zero budget counts as one
    for (int k = 0; k < N_CYC; k++) ev[k] = (k * 7) % 10;
    load_tbl();
    pmax_i = 8'd0; dly_shift_i = 8'd1; dly_cap_i = 8'd4;
    run_test(0, 0, tot);

    // R6 exact Etotal/P
    etot = 0;
    for (int k = 0; k < N_CYC; k++) begin ev[k] = 4 * (3 + (k * 5) % 11); etot += ev[k]; end
    load_tbl();
    pmax_i = 8'd4; dly_shift_i = 8'd1; dly_cap_i = 8'd1;
    run_test(0, 0, tot);
    chk(int'(elapsed_o) == etot / 4, "R6 Etotal over P", elapsed_o, etot / 4);

    // R5 fixed mode
    for (int k = 0; k < N_CYC; k++) ev[k] = (k * 53 + 7) % 90;
    load_tbl();
    pmax_i = 8'd6; dly_shift_i = 8'd2; dly_cap_i = 8'd5;
    run_test(1, 0, tot);
    pmax_i = 8'd30; dly_shift_i = 8'd11; dly_cap_i = 8'd5;
    run_test(1, 0, tot);

    // R8 R9 writes and start during a run, then rerun on the same table
    pmax_i = 8'd5; dly_shift_i = 8'd2; dly_cap_i = 8'd6;
    run_test(0, 1, tot);
    run_test(0, 0, tot);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errs++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, errs);
      $finish;
    end
  end
endmodule